// File: doc/BRIEF.md
# Recursive Double-Pole Line Smoother

This block smooths a stream of 8-bit luminance samples one line at a time. It uses a recursive low-pass response whose transfer function is a squared single pole with unity gain at DC, (1-γ)²/(1-γz⁻¹)². The same instance can serve any smoothing pass, forward or reverse, horizontal or vertical. A rotating line or frame store in front of it decides which way the pixels arrive. A start-of-line flag marks the first sample of every line, and the output carries its own valid strobe a fixed number of cycles after each input sample.

The response is built as two identical first-order sections in cascade, and each section is one pipeline stage. The pole γ = 1 − 2^-(k+1) is picked by a 3-bit code k. Multiplying by (1−γ) is then an arithmetic right shift by k+1, so the logic cost is the same for every code. The state keeps a fractional part below the pixel bits. The last stage rounds to the nearest integer and clamps to the pixel range.

The code is sampled only on a start-of-line sample and held for the whole line. The start-of-line sample also preloads both sections with the input value. As a result, no line begins with a ramp from black.

Top module: `smooth_iir2`

## Requirements
- R1: Every input sample with `pix_vld` high gives exactly one output with `smo_vld` high, 3 clock edges later. `smo_vld` is low in every other cycle, including when `pix_vld` has gaps.
- R2: An output produced by a sample with `pix_sol` high equals that sample's `pix_in`, whatever the earlier state was.
- R3: Each of the two sections holds a state s with 8 fraction bits. On a non-start sample with input u, it computes s ← s + ((u − s) >>> (k+1)), where >>> is an arithmetic shift with floor rounding. The first section's input is `pix_in`·256. The second section's input is the first section's new state.
- R4: The output is floor(s2/256 + 1/2), clamped to 0..255. An all-255 line gives 255 on every output.
- R5: A line of constant value produces that same value on every output (unity DC gain).
- R6: The code `gamma_sel` is taken only from a start-of-line sample. A change in the middle of a line has no effect before the next start-of-line sample.
- R7: Cycles with `pix_vld` low leave both section states unchanged. A line sent with gaps yields the same output values as the same line sent back to back.
- R8: While `rst_n` is low, `smo_vld` is 0 and `smo_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pix_vld | input | 1 | Input sample strobe |
| pix_sol | input | 1 | Marks the first sample of a line (qualified by pix_vld) |
| pix_in | input | 8 | Input luminance sample |
| gamma_sel | input | 3 | Pole code k, γ = 1 − 2^-(k+1), sampled at start of line |
| smo_vld | output | 1 | Output sample strobe |
| smo_out | output | 8 | Smoothed, rounded and clamped sample |

## Verification
Each result appears exactly three clock edges after the input sample that causes it: one edge per section and one for the rounding register. The bench drives inputs on falling edges and keeps a three-deep line of expected values. At each falling edge it compares the outputs with the entry that entered three falling edges earlier, and only then drives the next sample. The same check runs in idle cycles to confirm that the strobe stays low. Reset behaviour is checked while reset is held, with no latency involved.

// File: rtl/smooth_pkg.sv
package smooth_pkg;

  // Right-shift amount that realises the factor (1 - gamma) for a pole code.
  function automatic int unsigned pole_shift(input int unsigned code);
    return code + 1;
  endfunction

  // Fixed-point state width for a given pixel and fraction width (one guard bit).
  function automatic int unsigned state_width(input int unsigned pix_w,
                                              input int unsigned frac_w);
    return pix_w + frac_w + 1;
  endfunction

endpackage

// File: rtl/smooth_coef.sv
module smooth_coef #(
  parameter int CODE_W = 3,
  parameter int SH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic              in_sol,
  input  logic [CODE_W-1:0] code,
  output logic [SH_W-1:0]   sh_cur
);
  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] sh_fresh;
  logic [SH_W-1:0] sh_nxt;
  logic            take;

  always_comb begin
    sh_fresh = SH_W'(smooth_pkg::pole_shift(int'(code)));
    take     = in_vld && in_sol;
    sh_nxt   = take ? sh_fresh : sh_q;
    sh_cur   = in_sol ? sh_fresh : sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= SH_W'(smooth_pkg::pole_shift(0));
    end else if (take) begin
      sh_q <= sh_nxt;
    end
  end
endmodule

// File: rtl/smooth_pole.sv
module smooth_pole #(
  parameter int SW   = 17,
  parameter int SH_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic                 in_sol,
  input  logic [SH_W-1:0]      in_sh,
  input  logic signed [SW-1:0] in_data,
  output logic                 out_vld,
  output logic                 out_sol,
  output logic [SH_W-1:0]      out_sh,
  output logic signed [SW-1:0] out_data
);
  logic signed [SW:0]   diff;
  logic signed [SW:0]   step;
  logic signed [SW-1:0] acc;
  logic signed [SW-1:0] data_nxt;

  always_comb begin
    diff     = {in_data[SW-1], in_data} - {out_data[SW-1], out_data};
    step     = diff >>> in_sh;
    acc      = out_data + step[SW-1:0];
    data_nxt = in_sol ? in_data : acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sol  <= 1'b0;
      out_sh   <= '0;
      out_data <= '0;
    end else if (in_vld) begin
      out_sol  <= in_sol;
      out_sh   <= in_sh;
      out_data <= data_nxt;
    end
  end
endmodule

// File: rtl/smooth_round.sv
module smooth_round #(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 8,
  parameter int SW     = 17
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic signed [SW-1:0] in_data,
  output logic                 out_vld,
  output logic [PIX_W-1:0]     out_pix
);
  localparam int HALF = 1 << (FRAC_W - 1);

  logic signed [SW:0]  rnd;
  logic signed [SW:0]  quo;
  logic [PIX_W-1:0]    pix_nxt;

  always_comb begin
    rnd = {in_data[SW-1], in_data} + $signed((SW+1)'(HALF));
    quo = rnd >>> FRAC_W;
    if (rnd[SW]) begin
      pix_nxt = '0;
    end else if (|quo[SW:PIX_W]) begin
      pix_nxt = '1;
    end else begin
      pix_nxt = quo[PIX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_pix <= '0;
    end else if (in_vld) begin
      out_pix <= pix_nxt;
    end
  end
endmodule

// File: rtl/smooth_iir2.sv
module smooth_iir2 #(
  parameter int PIX_W   = 8,
  parameter int FRAC_W  = 8,
  parameter int CODE_W  = 3,
  parameter int N_POLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_vld,
  input  logic              pix_sol,
  input  logic [PIX_W-1:0]  pix_in,
  input  logic [CODE_W-1:0] gamma_sel,
  output logic              smo_vld,
  output logic [PIX_W-1:0]  smo_out
);
  localparam int SW     = int'(smooth_pkg::state_width(PIX_W, FRAC_W));
  localparam int MAX_SH = 1 << CODE_W;
  localparam int SH_W   = $clog2(MAX_SH + 1);

  logic                 stg_vld  [N_POLES+1];
  logic                 stg_sol  [N_POLES+1];
  logic [SH_W-1:0]      stg_sh   [N_POLES+1];
  logic signed [SW-1:0] stg_data [N_POLES+1];

  smooth_coef #(.CODE_W(CODE_W), .SH_W(SH_W)) i_coef (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (pix_vld),
    .in_sol (pix_sol),
    .code   (gamma_sel),
    .sh_cur (stg_sh[0])
  );

  always_comb begin
    stg_vld[0]  = pix_vld;
    stg_sol[0]  = pix_sol;
    stg_data[0] = {1'b0, pix_in, {FRAC_W{1'b0}}};
  end

  for (genvar k = 0; k < N_POLES; k++) begin : g_pole
    smooth_pole #(.SW(SW), .SH_W(SH_W)) i_pole (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_vld   (stg_vld[k]),
      .in_sol   (stg_sol[k]),
      .in_sh    (stg_sh[k]),
      .in_data  (stg_data[k]),
      .out_vld  (stg_vld[k+1]),
      .out_sol  (stg_sol[k+1]),
      .out_sh   (stg_sh[k+1]),
      .out_data (stg_data[k+1])
    );
  end

  smooth_round #(.PIX_W(PIX_W), .FRAC_W(FRAC_W), .SW(SW)) i_round (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (stg_vld[N_POLES]),
    .in_data (stg_data[N_POLES]),
    .out_vld (smo_vld),
    .out_pix (smo_out)
  );
endmodule

// File: rtl/smooth_iir2_chk.sv
module smooth_iir2_chk #(
  parameter int PIX_W   = 8,
  parameter int N_POLES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_vld,
  input logic             pix_sol,
  input logic [PIX_W-1:0] pix_in,
  input logic             smo_vld,
  input logic [PIX_W-1:0] smo_out
);
  localparam int LAT = N_POLES + 1;

  logic [LAT-1:0]   vd;
  logic [LAT-1:0]   sd;
  logic [PIX_W-1:0] pd [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vd <= '0;
      sd <= '0;
      for (int i = 0; i < LAT; i++) pd[i] <= '0;
    end else begin
      vd    <= {vd[LAT-2:0], pix_vld};
      sd    <= {sd[LAT-2:0], pix_vld && pix_sol};
      pd[0] <= pix_in;
      for (int i = 1; i < LAT; i++) pd[i] <= pd[i-1];
    end
  end

  // R1: one output strobe per input strobe, fixed latency
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    smo_vld == vd[LAT-1]);

  // R2: a start-of-line sample comes out unchanged
  a_r2_sol_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (smo_vld && sd[LAT-1]) |-> (smo_out == pd[LAT-1]));

  // R7: output holds between strobes
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !smo_vld |-> $stable(smo_out));

  // R8: quiet while reset is held
  a_r8_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!smo_vld && smo_out == '0));
endmodule

bind smooth_iir2 smooth_iir2_chk #(.PIX_W(PIX_W), .N_POLES(N_POLES)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pix_vld (pix_vld),
  .pix_sol (pix_sol),
  .pix_in  (pix_in),
  .smo_vld (smo_vld),
  .smo_out (smo_out)
);

// File: tb/test_smooth_iir2.sv
module test_smooth_iir2;
  localparam int CLK_PERIOD = 10;
  localparam int NTAB = 12;

  typedef struct packed {
    logic       v;
    logic       s;
    logic [2:0] c;
    logic [7:0] p;
    logic [7:0] e;
  } vec_t;

  // valid, start, code, pixel, expected output (worked by hand from R3/R4)
  localparam vec_t TBL [NTAB] = '{
    '{1'b1, 1'b1, 3'd0, 8'd100, 8'd100},
    '{1'b1, 1'b0, 3'd0, 8'd200, 8'd125},
    '{1'b1, 1'b0, 3'd0, 8'd200, 8'd150},
    '{1'b1, 1'b0, 3'd0, 8'd200, 8'd169},
    '{1'b1, 1'b0, 3'd0, 8'd0,   8'd131},
    '{1'b0, 1'b0, 3'd0, 8'd0,   8'd0},
    '{1'b1, 1'b1, 3'd1, 8'd0,   8'd0},
    '{1'b1, 1'b0, 3'd1, 8'd255, 8'd16},
    '{1'b1, 1'b0, 3'd1, 8'd255, 8'd40},
    '{1'b1, 1'b1, 3'd3, 8'd77,  8'd77},
    '{1'b1, 1'b0, 3'd3, 8'd77,  8'd77},
    '{1'b1, 1'b0, 3'd3, 8'd77,  8'd77}
  };

  logic       clk;
  logic       rst_n;
  logic       pix_vld;
  logic       pix_sol;
  logic [7:0] pix_in;
  logic [2:0] gamma_sel;
  logic       smo_vld;
  logic [7:0] smo_out;

  int    n_chk;
  int    n_bad;
  bit    done;
  logic  dv [3];
  int    de [3];
  string dt [3];
  longint m1, m2;
  int     msh;

  smooth_iir2 i_smooth_iir2 (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_vld   (pix_vld),
    .pix_sol   (pix_sol),
    .pix_in    (pix_in),
    .gamma_sel (gamma_sel),
    .smo_vld   (smo_vld),
    .smo_out   (smo_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int model_step(bit s, int code, int pix);
    longint e;
    if (s) begin
      msh = code + 1;
      m1  = longint'(pix) * 256;
      m2  = m1;
    end else begin
      m1 = m1 + ((longint'(pix) * 256 - m1) >>> msh);
      m2 = m2 + ((m1 - m2) >>> msh);
    end
    e = (m2 + 128) >>> 8;
    if (e < 0) e = 0;
    if (e > 255) e = 255;
    return int'(e);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_line();
    for (int i = 0; i < 3; i++) begin
      dv[i] = 1'b0; de[i] = 0; dt[i] = "R1 idle";
    end
  endtask

  // one falling edge: check the result due now, then drive the next sample
  task automatic step(bit v, bit s, int code, int pix, bit use_exp, int exp_in, string tag);
    int e;
    @(negedge clk);
    if (dv[2]) begin
      check(smo_vld === 1'b1, {dt[2], " strobe"}, int'(smo_vld), 1);
      check(smo_out === 8'(de[2]), dt[2], int'(smo_out), de[2]);
    end else begin
      check(smo_vld === 1'b0, "R1 strobe low", int'(smo_vld), 0);
    end
    dv[2] = dv[1]; de[2] = de[1]; dt[2] = dt[1];
    dv[1] = dv[0]; de[1] = de[0]; dt[1] = dt[0];
    pix_vld   = v;
    pix_sol   = s;
    pix_in    = 8'(pix);
    gamma_sel = 3'(code);
    e = 0;
    if (v) begin
      e = model_step(s, code, pix);
      if (use_exp) e = exp_in;
    end
    dv[0] = v; de[0] = e; dt[0] = tag;
  endtask

  task automatic flush();
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 0, 0, 1'b0, 0, "R1 idle");
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    m1 = 0; m2 = 0; msh = 1;
    clear_line();
    rst_n = 1'b0; pix_vld = 1'b0; pix_sol = 1'b0; pix_in = '0; gamma_sel = '0;
    repeat (3) @(negedge clk);
    check(smo_vld === 1'b0, "R8 reset strobe", int'(smo_vld), 0);
    check(smo_out === 8'd0, "R8 reset data", int'(smo_out), 0);
    rst_n = 1'b1;

    // table walk: R2 start values, R3 recursion, R4 rounding, R5 constant line
    for (int i = 0; i < NTAB; i++) begin
      step(TBL[i].v, TBL[i].s, int'(TBL[i].c), int'(TBL[i].p), 1'b1, int'(TBL[i].e),
           TBL[i].s ? "R2 table" : (TBL[i].c == 3'd3 ? "R5 table" : "R3 table"));
    end
    flush();

    // R4: full-scale constant line must stay at 255 at the strongest pole
    for (int i = 0; i < 6; i++) step(1'b1, i == 0, 7, 255, 1'b1, 255, "R4 full scale");
    // R2: start sample resets history after a bright line
    step(1'b1, 1'b1, 2, 3, 1'b1, 3, "R2 restart");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 2, 180, 1'b0, 0, "R3 code2 step");
    flush();

    // R6: code changes mid-line; model keeps the line's code (shift 1)
    step(1'b1, 1'b1, 0, 10, 1'b0, 0, "R6 start");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 7, 240, 1'b0, 0, "R6 mid-line code change");
    step(1'b1, 1'b1, 7, 240, 1'b0, 0, "R6 new line");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 7, 20, 1'b0, 0, "R6 code7 applied");
    flush();

    // R7: same line with gaps, results must match back-to-back model
    step(1'b1, 1'b1, 1, 50, 1'b0, 0, "R7 start");
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 1'b1, 5, 255, 1'b0, 0, "R1 gap");
      step(1'b1, 1'b0, 1, 50 + 20 * i, 1'b0, 0, "R7 gapped line");
    end
    flush();

    // R3: long ramp at several codes
    for (int c = 0; c < 8; c++) begin
      step(1'b1, 1'b1, c, 0, 1'b0, 0, "R2 ramp start");
      for (int i = 0; i < 12; i++) step(1'b1, 1'b0, c, (i * 37) % 256, 1'b0, 0, "R3 ramp");
    end
    flush();

    // R8: reset in mid-stream
    step(1'b1, 1'b1, 0, 99, 1'b0, 0, "R2 pre-reset");
    step(1'b1, 1'b0, 0, 99, 1'b0, 0, "R5 pre-reset");
    @(negedge clk);
    rst_n = 1'b0; pix_vld = 1'b0;
    clear_line();
    @(negedge clk);
    check(smo_vld === 1'b0, "R8 mid reset strobe", int'(smo_vld), 0);
    check(smo_out === 8'd0, "R8 mid reset data", int'(smo_out), 0);
    rst_n = 1'b1;
    step(1'b1, 1'b1, 4, 201, 1'b0, 0, "R2 after reset");
    flush();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule